// File: doc/BRIEF.md
# Digital XOR Phase Duty Meter

This block measures the phase offset between a reference square wave and the squared-up output of a resonant LC network without any analog filter or converter. Both inputs are brought into the clock domain through two-flop synchronisers and combined by an XOR. Their phase offset shows up as the fraction of time this XOR is high. A fast clock counts the XOR-high cycles over a gate window whose length is a programmable number of clock cycles. At the end of each window the count is published with a one-cycle strobe.

At a 150 MHz count clock with a 1 ms gate, one window holds about 150,000 cycles, which is roughly 17 bits of result. The reference frequency is normally placed close to the LC resonance. The count then follows an arctangent-shaped curve of the capacitance change, and that curve is linearised further down the chain. An optional averager folds a power-of-two number of consecutive windows into one lower-noise result.

Top module: `phase_duty_meter`

## Requirements
- R1: While `rst_n` is low, `high_count` and `avg_count` are zero and `count_valid` and `avg_valid` are low.
- R2: When a window closes, `high_count` equals the number of clock cycles inside that window in which the synchronised `ref_in` XOR `lc_in` was 1. For two 50%-duty waves of period P cycles offset by D cycles (D ≤ P/2), and a window length that is a multiple of P, this is window_length × 2D / P.
- R3: Each input passes through two flops before the XOR. An input change driven between clock edges t_j and t_(j+1) is first counted at edge t_(j+3). If the change is driven j cycles after a window opens, a window of N cycles therefore counts N − j − 2 of the new cycles.
- R4: A window lasts `gate_len` clock cycles, and `count_valid` is high for exactly one cycle at its close, so strobes are `gate_len` cycles apart.
- R5: A new `gate_len` value is sampled only at a window close. The window already running keeps its old length.
- R6: A `gate_len` of 0 or 1 makes every clock cycle a full window, so `count_valid` stays high and `high_count` is 0 or 1 each cycle.
- R7: The count saturates at 2^CNT_W − 1 and does not wrap.
- R8: With AVG_LOG2 > 0, every 2^AVG_LOG2 published windows produce `avg_count` = floor(sum of those counts / 2^AVG_LOG2), with a one-cycle `avg_valid` one clock after the last of those windows' `count_valid`. With AVG_LOG2 = 0, the averager passes each count through one clock later.
- R9: `high_count` changes only on a `count_valid` cycle, and `avg_count` changes only on an `avg_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference square wave, asynchronous |
| lc_in | input | 1 | Limited LC output square wave, asynchronous |
| gate_len | input | GATE_W | Window length in clock cycles |
| high_count | output | CNT_W | XOR-high cycle count of the last window |
| count_valid | output | 1 | One-cycle strobe at each window close |
| avg_count | output | CNT_W | Mean of the last group of windows |
| avg_valid | output | 1 | One-cycle strobe for a new mean |

## Verification
The bench builds the block with CNT_W = 10, GATE_W = 12 and AVG_LOG2 = 2. With a 10-bit count, saturation is reached by a 1500-cycle window held fully high. A 4-window averager gives a fresh mean every few hundred cycles. Periodic wave pairs with known period and offset give exact expected counts regardless of where a window starts. Constant inputs make the count equal the window length, which exposes the window-boundary behaviour and the synchroniser latency.

// File: rtl/phase_duty_pkg.sv
// Package: shared types and defaults for the XOR phase duty meter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package phase_duty_pkg;

    // Default count width: 2^20 exceeds a 1 ms gate at 150 MHz.
    localparam int unsigned DEF_CNT_W  = 20;
    // Default gate width: holds 150000 cycles.
    localparam int unsigned DEF_GATE_W = 18;

    // Window sequencer state.
    typedef enum logic {
        WIN_LOAD = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;

endpackage

// File: rtl/pd_sync2.sv
// Module: pd_sync2
// Two-flop synchroniser for WIDTH independent single-bit asynchronous
// inputs. Assumes each bit is a level that is stable for more than one clock;
// there is no bus coherence between bits.
module pd_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stable_q;

            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= async_in[b];
                    stable_q <= meta_q;
                end
            end

            assign sync_out[b] = stable_q;
        end
    endgenerate

endmodule

// File: rtl/pd_gate_timer.sv
// Module: pd_gate_timer
// Cuts time into back-to-back windows of gate_len cycles. The length is
// sampled into a shadow register once after reset and at every window
// close, so a change never shortens or stretches the running window.
// Lengths 0 and 1 both give one-cycle windows.
module pd_gate_timer
    import phase_duty_pkg::*;
#(
    parameter int unsigned GATE_W = DEF_GATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GATE_W-1:0] gate_len,
    output logic              win_open,
    output logic              win_end
);

    win_state_e        state_q;
    logic [GATE_W-1:0] len_q;
    logic [GATE_W-1:0] tick_q;
    logic              last_tick;

    // Last cycle of the window: short lengths close at once.
    always_comb begin
        last_tick = (len_q <= GATE_W'(1)) || (tick_q == (len_q - GATE_W'(1)));
    end

    assign win_open = (state_q == WIN_RUN);
    assign win_end  = win_open && last_tick;

    // Sequence loading, counting and closing of windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_LOAD;
            len_q   <= '0;
            tick_q  <= '0;
        end else if (state_q == WIN_LOAD) begin
            state_q <= WIN_RUN;
            len_q   <= gate_len;
            tick_q  <= '0;
        end else if (last_tick) begin
            len_q   <= gate_len;
            tick_q  <= '0;
        end else begin
            tick_q  <= tick_q + GATE_W'(1);
        end
    end

endmodule

// File: rtl/pd_duty_counter.sv
// Module: pd_duty_counter
// Counts the cycles of an open window in which hit is high, with
// saturation at all-ones. At the window close it publishes the total,
// including the closing cycle, and raises a one-cycle strobe.
module pd_duty_counter
    import phase_duty_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             win_open,
    input  logic             win_end,
    output logic [CNT_W-1:0] high_count,
    output logic             count_valid
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] acc_next;

    // Saturating increment of the running total.
    always_comb begin
        acc_next = (hit && (acc_q != CNT_MAX)) ? acc_q + CNT_W'(1) : acc_q;
    end

    // Accumulate inside the window and clear at its close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!win_open || win_end) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

    // Publish the total and the strobe at the window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_count  <= '0;
            count_valid <= 1'b0;
        end else begin
            count_valid <= win_end;
            if (win_end) begin
                high_count <= acc_next;
            end
        end
    end

endmodule

// File: rtl/pd_window_avg.sv
// Module: pd_window_avg
// Averages groups of 2^AVG_LOG2 published window counts by summing and
// shifting right. AVG_LOG2 = 0 selects a one-register pass-through.
// Assumes count_valid is a strobe and counts are unsigned.
module pd_window_avg
    import phase_duty_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned AVG_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] high_count,
    input  logic             count_valid,
    output logic [CNT_W-1:0] avg_count,
    output logic             avg_valid
);

    generate
        if (AVG_LOG2 == 0) begin : g_pass
            // Register each count unchanged.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    avg_count <= '0;
                    avg_valid <= 1'b0;
                end else begin
                    avg_valid <= count_valid;
                    if (count_valid) begin
                        avg_count <= high_count;
                    end
                end
            end
        end else begin : g_avg
            localparam int unsigned SUM_W = CNT_W + AVG_LOG2;

            logic [SUM_W-1:0]    sum_q;
            logic [SUM_W-1:0]    sum_next;
            logic [AVG_LOG2-1:0] grp_q;

            // Running sum including the arriving count.
            always_comb begin
                sum_next = sum_q + SUM_W'(high_count);
            end

            // Collect the group and emit its mean on the last member.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sum_q     <= '0;
                    grp_q     <= '0;
                    avg_count <= '0;
                    avg_valid <= 1'b0;
                end else begin
                    avg_valid <= 1'b0;
                    if (count_valid) begin
                        if (&grp_q) begin
                            avg_count <= sum_next[SUM_W-1:AVG_LOG2];
                            avg_valid <= 1'b1;
                            sum_q     <= '0;
                            grp_q     <= '0;
                        end else begin
                            sum_q     <= sum_next;
                            grp_q     <= grp_q + AVG_LOG2'(1);
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/phase_duty_meter.sv
// Module: phase_duty_meter (top)
// Measures the phase offset of two square waves as the number of cycles,
// per gate window, in which their synchronised XOR is high. Optionally
// averages groups of windows. Assumes both inputs are clean logic-level
// squares, asynchronous to clk and slower than clk/2.
module phase_duty_meter
    import phase_duty_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned GATE_W   = DEF_GATE_W,
    parameter int unsigned AVG_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              lc_in,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  high_count,
    output logic              count_valid,
    output logic [CNT_W-1:0]  avg_count,
    output logic              avg_valid
);

    logic [1:0] sync_pair;
    logic       xor_hit;
    logic       win_open;
    logic       win_end;

    pd_sync2 #(.WIDTH(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({lc_in, ref_in}),
        .sync_out (sync_pair)
    );

    // Phase detector: high while the two synchronised waves disagree.
    assign xor_hit = sync_pair[0] ^ sync_pair[1];

    pd_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_len (gate_len),
        .win_open (win_open),
        .win_end  (win_end)
    );

    pd_duty_counter #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (xor_hit),
        .win_open    (win_open),
        .win_end     (win_end),
        .high_count  (high_count),
        .count_valid (count_valid)
    );

    pd_window_avg #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2)) u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .high_count  (high_count),
        .count_valid (count_valid),
        .avg_count   (avg_count),
        .avg_valid   (avg_valid)
    );

endmodule

// File: rtl/pd_meter_chk.sv
// Module: pd_meter_chk
// Property checker for phase_duty_meter, attached by bind below.
module pd_meter_chk #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             lc_in,
    input  logic             hit,
    input  logic [CNT_W-1:0] high_count,
    input  logic             count_valid,
    input  logic [CNT_W-1:0] avg_count,
    input  logic             avg_valid
);

    localparam int unsigned EL_W = CNT_W + 1;

    logic [1:0]      since_rst_q;
    logic [EL_W-1:0] elapsed_q;

    // Count clocks since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 2'd3) begin
            since_rst_q <= since_rst_q + 2'd1;
        end
    end

    // Cycles since the previous strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || count_valid) begin
            elapsed_q <= '0;
        end else if (elapsed_q != {EL_W{1'b1}}) begin
            elapsed_q <= elapsed_q + EL_W'(1);
        end
    end

    // R3
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 2'd2) |-> (hit == ($past(ref_in, 2) ^ $past(lc_in, 2))));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_valid |-> $stable(high_count));

    // R9
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |-> $stable(avg_count));

    // R8
    avg_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> $past(count_valid));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |-> (EL_W'(high_count) <= elapsed_q + EL_W'(1)));

endmodule

bind phase_duty_meter pd_meter_chk #(.CNT_W(CNT_W)) u_meter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_in      (ref_in),
    .lc_in       (lc_in),
    .hit         (xor_hit),
    .high_count  (high_count),
    .count_valid (count_valid),
    .avg_count   (avg_count),
    .avg_valid   (avg_valid)
);

// File: tb/test_phase_duty_meter.sv
// Bench for phase_duty_meter: vector table of wave pairs, then directed tests.
module test_phase_duty_meter;

    localparam int CNT_W    = 10;
    localparam int GATE_W   = 12;
    localparam int AVG_LOG2 = 2;

    // period, offset, gate length, expected count (R2)
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{8, 0, 64, 0},   '{8, 2, 64, 32},   '{8, 1, 64, 16},   '{8, 4, 64, 64},
        '{10, 3, 100, 60}, '{16, 5, 160, 100}, '{12, 6, 48, 48}, '{20, 7, 200, 140}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_in;
    logic              lc_in;
    logic [GATE_W-1:0] gate_len = GATE_W'(16);
    logic [CNT_W-1:0]  high_count;
    logic              count_valid;
    logic [CNT_W-1:0]  avg_count;
    logic              avg_valid;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   wave_on = 1'b0;
    logic c_ref = 1'b0;
    logic c_lc = 1'b0;
    logic w_ref = 1'b0;
    logic w_lc = 1'b0;
    int   ph = 0;
    int   per = 8;
    int   off = 0;

    always #10 clk = ~clk;

    // Periodic wave pair generator, updated away from the active edge.
    always @(negedge clk) begin
        ph <= ph + 1;
        w_ref <= ((ph % per) < per / 2);
        w_lc  <= (((ph + per - off) % per) < per / 2);
    end

    assign ref_in = wave_on ? w_ref : c_ref;
    assign lc_in  = wave_on ? w_lc  : c_lc;

    phase_duty_meter #(.CNT_W(CNT_W), .GATE_W(GATE_W), .AVG_LOG2(AVG_LOG2)) i_phase_duty_meter (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .lc_in(lc_in), .gate_len(gate_len),
        .high_count(high_count), .count_valid(count_valid),
        .avg_count(avg_count), .avg_valid(avg_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!count_valid);
    endtask

    task automatic wait_avg();
        do @(negedge clk); while (!avg_valid);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check("R1 high_count in reset", int'(high_count), 0);
        check("R1 count_valid in reset", int'(count_valid), 0);
        check("R1 avg_count in reset", int'(avg_count), 0);
        check("R1 avg_valid in reset", int'(avg_valid), 0);
        rst_n = 1'b1;

        // R2 and R8: vector table of wave pairs
        wave_on = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            per = VEC[v][0];
            off = VEC[v][1];
            gate_len = GATE_W'(VEC[v][2]);
            wait_valid();
            wait_valid();
            check($sformatf("R2 vector %0d count", v), int'(high_count), VEC[v][3]);
            wait_avg();
            wait_avg();
            check($sformatf("R8 vector %0d average", v), int'(avg_count), VEC[v][3]);
        end

        // R4 and R5: constant XOR high makes the count equal the window length
        wave_on = 1'b0;
        c_ref = 1'b1;
        c_lc = 1'b0;
        gate_len = GATE_W'(40);
        wait_valid();
        wait_valid();
        check("R4 window of 40", int'(high_count), 40);
        @(negedge clk);
        check("R4 strobe lasts one cycle", int'(count_valid), 0);
        repeat (4) @(negedge clk);
        gate_len = GATE_W'(25);
        wait_valid();
        check("R5 running window keeps old length", int'(high_count), 40);
        begin
            int gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!count_valid);
            check("R4 strobe spacing", gap, 25);
            check("R5 new length used", int'(high_count), 25);
        end

        // R3: synchroniser latency
        c_ref = 1'b0;
        gate_len = GATE_W'(20);
        wait_valid();
        wait_valid();
        wait_valid();
        check("R3 quiet window", int'(high_count), 0);
        repeat (10) @(negedge clk);
        c_ref = 1'b1;
        wait_valid();
        check("R3 late change counts N-j-2", int'(high_count), 8);
        wait_valid();
        check("R3 following full window", int'(high_count), 20);

        // R6: one-cycle windows for lengths 1 and 0
        gate_len = GATE_W'(1);
        wait_valid();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 gate 1 strobe", int'(count_valid), 1);
            check("R6 gate 1 count", int'(high_count), 1);
        end
        gate_len = GATE_W'(0);
        c_ref = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 gate 0 strobe", int'(count_valid), 1);
        check("R6 gate 0 count", int'(high_count), 0);

        // R7: saturation
        c_ref = 1'b1;
        gate_len = GATE_W'(1500);
        wait_valid();
        wait_valid();
        check("R7 saturated count", int'(high_count), 1023);

        // R1: reset in mid-run
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-run reset count", int'(high_count), 0);
        check("R1 mid-run reset average", int'(avg_count), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule